// File: doc/BRIEF.md
# Constrained Cross Deringing Filter

This block smooths one pixel per clock with a non-linear low-pass filter. Eight neighbours are used: two above, two below, two to the left and two to the right of the centre pixel. Each neighbour's difference from the centre first passes through a clamp that keeps its sign. The clamp's limit shrinks as the difference grows, so strong edges are left mostly untouched while small ringing ripples are pulled toward the centre. The clamped values are weighted, summed and rounded, and the result is added to the centre pixel.

The caller gathers the neighbours and supplies them on one bus together with the centre pixel, a strength and a damping value. The block is a fixed three-stage pipeline with no stall. A result leaves three clocks after its operands enter, with a valid flag travelling alongside.

At the default pixel width of 8 bits, every neighbour difference is saturated to the signed 8-bit range before the clamp. At wider pixel widths the full difference is kept.

Top module: `dering_cross_filter`

## Requirements
- R1: For each tap, d = neighbour − centre (saturated to [−128, 127] when PIX_W is 8). The clamped value is sign(d) × min(|d|, L), where L = strength − (|d| >> shift) and L is floored at 0.
- R2: shift equals damping minus the index of the highest set bit of strength, floored at 0. When strength is 0, that index is taken as 0.
- R3: The tap lanes of nbr_bus are PIX_W bits each. Lane 0 is two rows up, 1 is one row up, 2 is one row down, 3 is two rows down, 4 is two columns left, 5 is one column left, 6 is one column right and 7 is two columns right. Lanes 1, 2, 5 and 6 have weight 3; the other lanes have weight 1. delta is the weighted sum of the clamped values.
- R4: The correction is (delta + 8 − (delta < 0 ? 1 : 0)) arithmetically shifted right by 4. This rounds symmetrically, so equal positive and negative deltas give corrections of equal magnitude.
- R5: out_pix equals centre plus the correction, clamped to [0, 2^PIX_W − 1]. It never moves more than strength away from centre.
- R6: With strength 0, out_pix equals centre for any neighbours and any damping.
- R7: After reset, out_valid and out_pix are 0. out_valid equals in_valid from exactly 3 clocks earlier.
- R8: A new pixel may enter on every clock. Each result depends only on its own operands, whether inputs arrive back-to-back or with gaps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands on this clock are a pixel to filter |
| centre | input | PIX_W | Pixel being filtered |
| nbr_bus | input | 8*PIX_W | Eight neighbour pixels, lane order as in R3 |
| strength | input | STR_W | Clamp strength |
| damping | input | DMP_W | Damping before the strength-dependent adjustment |
| out_valid | output | 1 | out_pix holds a result |
| out_pix | output | PIX_W | Filtered pixel |

## Verification
Difference saturation and the damping floor can both act on the same tap in the same cycle. This happens when a dark centre meets bright neighbours while damping is below the top bit index of strength. Such a case is driven directly: the saturated difference must then meet a shift of zero and give a limit of zero, leaving the centre unchanged. A companion case uses damping large enough that the floor does not act, so saturation alone decides the limit. Both are judged against exact expected pixels. Randomized operands, issued back-to-back and with bubbles, check the two functions mixed with rounding of both signs.

// File: rtl/dering_pkg.sv
package dering_pkg;

    localparam int NUM_TAPS    = 8;
    localparam int ROUND_SHIFT = 4;
    localparam int ROUND_BIAS  = 1 << (ROUND_SHIFT - 1);
    localparam int NEAR_WEIGHT = 3;
    localparam int FAR_WEIGHT  = 1;

    // Lane order on the neighbour bus
    typedef enum logic [2:0] {
        TAP_N2, TAP_N1, TAP_S1, TAP_S2, TAP_W2, TAP_W1, TAP_E1, TAP_E2
    } tap_pos_e;

    function automatic int tap_weight(tap_pos_e p);
        case (p)
            TAP_N1, TAP_S1, TAP_W1, TAP_E1: return NEAR_WEIGHT;
            default:                        return FAR_WEIGHT;
        endcase
    endfunction

    // Index of the highest set bit; 0 for a zero operand
    function automatic logic [3:0] msb_pos16(input logic [15:0] v);
        logic [3:0] r;
        r = '0;
        for (int i = 0; i < 16; i++) begin
            if (v[i]) r = 4'(i);
        end
        return r;
    endfunction

endpackage

// File: rtl/dr_tap_limit.sv
module dr_tap_limit #(
    parameter int PIX_W = 8,
    parameter int STR_W = 4,
    parameter int SHF_W = 4
) (
    input  logic [PIX_W-1:0]   centre,
    input  logic [PIX_W-1:0]   nbr,
    input  logic [STR_W-1:0]   strength,
    input  logic [SHF_W-1:0]   shift,
    output logic signed [STR_W:0] con
);
    localparam int DW = PIX_W + 1;

    logic signed [DW-1:0] diff_raw;
    logic signed [DW-1:0] diff;
    logic [DW-1:0]        mag;
    logic [DW-1:0]        scaled;
    logic [STR_W-1:0]     lim;
    logic [STR_W-1:0]     kept;

    assign diff_raw = $signed({1'b0, nbr}) - $signed({1'b0, centre});

    generate
        if (PIX_W == 8) begin : g_sat8
            assign diff = (diff_raw > 9'sd127)  ? 9'sd127  :
                          (diff_raw < -9'sd128) ? -9'sd128 : diff_raw;
        end else begin : g_full
            assign diff = diff_raw;
        end
    endgenerate

    always_comb begin
        mag    = diff[DW-1] ? (~diff + DW'(1)) : diff;
        scaled = mag >> shift;
        lim    = (scaled >= DW'(strength)) ? '0 : (strength - scaled[STR_W-1:0]);
        kept   = (mag < DW'(lim)) ? mag[STR_W-1:0] : lim;
        con    = diff[DW-1] ? -$signed({1'b0, kept}) : $signed({1'b0, kept});
    end

    always_comb begin
        AST_TAP_BOUND: assert (kept <= strength && DW'(kept) <= mag); // R1
        AST_TAP_ZERO_STR: assert (strength != '0 || con == '0); // R6
    end

endmodule

// File: rtl/dr_tap_sum.sv
module dr_tap_sum import dering_pkg::*; #(
    parameter int STR_W = 4,
    parameter int SUM_W = 10
) (
    input  logic [NUM_TAPS*(STR_W+1)-1:0] con_bus,
    output logic [SUM_W-1:0]              delta
);
    localparam int CON_W = STR_W + 1;

    always_comb begin
        int acc;
        acc = 0;
        for (int i = 0; i < NUM_TAPS; i++) begin
            acc += tap_weight(tap_pos_e'(3'(i)))
                   * int'($signed(con_bus[i*CON_W +: CON_W]));
        end
        delta = SUM_W'(acc);
    end

endmodule

// File: rtl/dr_round_out.sv
module dr_round_out import dering_pkg::*; #(
    parameter int PIX_W = 8,
    parameter int SUM_W = 10
) (
    input  logic [PIX_W-1:0] centre,
    input  logic [SUM_W-1:0] delta,
    output logic [PIX_W-1:0] pix
);
    localparam int RES_W = PIX_W + SUM_W;

    logic signed [SUM_W-1:0] dl, bias, tpre, step;
    logic signed [RES_W-1:0] base, ext, total;

    always_comb begin
        dl    = $signed(delta);
        bias  = dl[SUM_W-1] ? SUM_W'(ROUND_BIAS - 1) : SUM_W'(ROUND_BIAS);
        tpre  = dl + bias;
        step  = tpre >>> ROUND_SHIFT;
        base  = $signed({{SUM_W{1'b0}}, centre});
        ext   = {{PIX_W{step[SUM_W-1]}}, step};
        total = base + ext;
        if (total[RES_W-1])            pix = '0;
        else if (|total[RES_W-2:PIX_W]) pix = '1;
        else                            pix = total[PIX_W-1:0];
    end

endmodule

// File: rtl/dering_cross_filter.sv
module dering_cross_filter import dering_pkg::*; #(
    parameter int PIX_W = 8,
    parameter int STR_W = 4,
    parameter int DMP_W = 4
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      in_valid,
    input  logic [PIX_W-1:0]          centre,
    input  logic [NUM_TAPS*PIX_W-1:0] nbr_bus,
    input  logic [STR_W-1:0]          strength,
    input  logic [DMP_W-1:0]          damping,
    output logic                      out_valid,
    output logic [PIX_W-1:0]          out_pix
);
    localparam int CON_W = STR_W + 1;
    localparam int SUM_W = STR_W + 6;
    localparam int BUS_W = NUM_TAPS * CON_W;

    typedef struct packed {
        logic             vld;
        logic [PIX_W-1:0] ctr;
        logic [STR_W-1:0] str;
        logic [BUS_W-1:0] cons;
    } lim_stage_t;

    typedef struct packed {
        logic             vld;
        logic [PIX_W-1:0] ctr;
        logic [STR_W-1:0] str;
        logic [SUM_W-1:0] delta;
    } sum_stage_t;

    typedef struct packed {
        logic             vld;
        logic [PIX_W-1:0] pix;
    } out_stage_t;

    logic [3:0]       str_msb;
    logic [DMP_W-1:0] adj_shift;
    logic [BUS_W-1:0] con_now;
    logic [SUM_W-1:0] delta_now;
    logic [PIX_W-1:0] pix_now;
    lim_stage_t       s1;
    sum_stage_t       s2;
    out_stage_t       s3;

    // Damping shift, shared by all taps
    always_comb begin
        str_msb = msb_pos16(16'(strength));
        if (int'(damping) > int'(str_msb))
            adj_shift = DMP_W'(int'(damping) - int'(str_msb));
        else
            adj_shift = '0;
    end

    always_comb begin
        AST_ADJ_FLOOR: assert (adj_shift <= damping); // R2
    end

    for (genvar g = 0; g < NUM_TAPS; g++) begin : g_tap
        dr_tap_limit #(.PIX_W(PIX_W), .STR_W(STR_W), .SHF_W(DMP_W)) u_tap (
            .centre   (centre),
            .nbr      (nbr_bus[g*PIX_W +: PIX_W]),
            .strength (strength),
            .shift    (adj_shift),
            .con      (con_now[g*CON_W +: CON_W])
        );
    end

    dr_tap_sum #(.STR_W(STR_W), .SUM_W(SUM_W)) u_sum (
        .con_bus (s1.cons),
        .delta   (delta_now)
    );

    dr_round_out #(.PIX_W(PIX_W), .SUM_W(SUM_W)) u_rnd (
        .centre (s2.ctr),
        .delta  (s2.delta),
        .pix    (pix_now)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            s1 <= '0;
            s2 <= '0;
            s3 <= '0;
        end else begin
            s1 <= '{vld: in_valid, ctr: centre, str: strength, cons: con_now};
            s2 <= '{vld: s1.vld, ctr: s1.ctr, str: s1.str, delta: delta_now};
            s3 <= '{vld: s2.vld, pix: pix_now};
        end
    end

    assign out_valid = s3.vld;
    assign out_pix   = s3.pix;

    // Cycles since reset, saturating, for the latency check
    logic [1:0] age;
    always_ff @(posedge clk) begin
        if (rst)              age <= '0;
        else if (age != 2'd3) age <= age + 2'd1;
    end

    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (rst)
        (age == 2'd3) |-> (out_valid == $past(in_valid, 3))); // R7
    AST_STEP_LIMIT: assert property (@(posedge clk) disable iff (rst)
        s2.vld |=> (int'(out_pix) <= int'($past(s2.ctr)) + int'($past(s2.str))
                 && int'(out_pix) + int'($past(s2.str)) >= int'($past(s2.ctr)))); // R5
    AST_ZERO_STR_HOLD: assert property (@(posedge clk) disable iff (rst)
        (s2.vld && s2.str == '0) |=> (out_pix == $past(s2.ctr))); // R6
    AST_POS_NOT_DOWN: assert property (@(posedge clk) disable iff (rst)
        (s2.vld && !s2.delta[SUM_W-1]) |=> (out_pix >= $past(s2.ctr))); // R4
    AST_NEG_NOT_UP: assert property (@(posedge clk) disable iff (rst)
        (s2.vld && s2.delta[SUM_W-1]) |=> (out_pix <= $past(s2.ctr))); // R4

endmodule

// File: tb/sim_dering_cross_filter.sv
module sim_dering_cross_filter;

    localparam int CLK_PERIOD = 10;
    localparam int PW = 8;
    localparam int SW = 4;
    localparam int DW = 4;
    localparam int NT = 8;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             in_valid = 1'b0;
    logic [PW-1:0]    centre = '0;
    logic [NT*PW-1:0] nbr_bus = '0;
    logic [SW-1:0]    strength = '0;
    logic [DW-1:0]    damping = '0;
    logic             out_valid;
    logic [PW-1:0]    out_pix;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    logic    hv[3];
    int      hp[3];
    string   ht[3];

    always #(CLK_PERIOD/2) clk = ~clk;

    dering_cross_filter #(.PIX_W(PW), .STR_W(SW), .DMP_W(DW)) u0 (
        .clk, .rst, .in_valid, .centre, .nbr_bus, .strength, .damping,
        .out_valid, .out_pix
    );

    function automatic int ref_pix(int x, logic [NT*PW-1:0] nb, int s, int d);
        int msb, adj, delta, t, r;
        msb = 0;
        for (int i = 0; i < 16; i++) if (((s >> i) & 1) != 0) msb = i;
        adj = d - msb;
        if (adj < 0) adj = 0;
        delta = 0;
        for (int i = 0; i < NT; i++) begin
            int df, a, lim, c, w;
            df = int'(nb[i*PW +: PW]) - x;
            if (PW == 8) begin
                if (df > 127)  df = 127;
                if (df < -128) df = -128;
            end
            a = (df < 0) ? -df : df;
            lim = s - (a >> adj);
            if (lim < 0) lim = 0;
            c = (a < lim) ? a : lim;
            if (df < 0) c = -c;
            w = (i == 1 || i == 2 || i == 5 || i == 6) ? 3 : 1;
            delta += w * c;
        end
        t = delta + 8;
        if (delta < 0) t -= 1;
        t = t >>> 4;
        r = x + t;
        if (r < 0) r = 0;
        if (r > (1 << PW) - 1) r = (1 << PW) - 1;
        return r;
    endfunction

    task automatic step(input logic v, input int x, input logic [NT*PW-1:0] nb,
                        input int s, input int d, input string tag);
        @(negedge clk);
        n_chk++;
        if (out_valid !== hv[2] || (hv[2] && int'(out_pix) != hp[2])) begin
            n_fail++;
            $display("FAIL %s: valid=%0b pix=%0d expected valid=%0b pix=%0d",
                     ht[2], out_valid, out_pix, hv[2], hp[2]);
        end
        hv[2] = hv[1]; hp[2] = hp[1]; ht[2] = ht[1];
        hv[1] = hv[0]; hp[1] = hp[0]; ht[1] = ht[0];
        in_valid = v;
        centre   = PW'(x);
        nbr_bus  = nb;
        strength = SW'(s);
        damping  = DW'(d);
        hv[0] = v;
        hp[0] = ref_pix(x, nb, s, d);
        ht[0] = tag;
    endtask

    function automatic logic [NT*PW-1:0] flat(int x);
        logic [NT*PW-1:0] b;
        for (int i = 0; i < NT; i++) b[i*PW +: PW] = PW'(x);
        return b;
    endfunction

    function automatic logic [NT*PW-1:0] one_lane(int x, int lane, int val);
        logic [NT*PW-1:0] b;
        b = flat(x);
        b[lane*PW +: PW] = PW'(val);
        return b;
    endfunction

    function automatic logic [NT*PW-1:0] rnd_bus(int x, bit wide);
        logic [NT*PW-1:0] b;
        for (int i = 0; i < NT; i++) begin
            int v;
            if (wide) v = int'($urandom % 256);
            else      v = x + int'($urandom % 41) - 20;
            if (v < 0) v = 0;
            if (v > 255) v = 255;
            b[i*PW +: PW] = PW'(v);
        end
        return b;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL R7: watchdog expired, actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2718));
        for (int i = 0; i < 3; i++) begin hv[i] = 1'b0; hp[i] = 0; ht[i] = "R7"; end
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        n_chk++;
        if (out_valid !== 1'b0 || out_pix !== '0) begin   // R7 reset state
            n_fail++;
            $display("FAIL R7: reset valid=%0b pix=%0d expected valid=0 pix=0",
                     out_valid, out_pix);
        end

        // R3 flat area leaves pixel unchanged; single near and far taps
        step(1, 100, flat(100), 15, 15, "R3");
        step(1, 100, one_lane(100, 1, 110), 15, 15, "R3");
        step(1, 100, one_lane(100, 0, 110), 15, 15, "R3");
        step(1, 100, one_lane(100, 6, 90), 15, 15, "R3");
        step(1, 100, one_lane(100, 4, 90), 15, 15, "R3");
        // R4 symmetric rounding around zero
        step(1, 50, one_lane(50, 3, 43), 15, 15, "R4");
        step(1, 50, one_lane(50, 3, 57), 15, 15, "R4");
        step(1, 50, one_lane(50, 7, 42), 15, 15, "R4");
        step(1, 50, one_lane(50, 7, 58), 15, 15, "R4");
        // R2 damping shift: strength 4 (top bit 2), damping 3 -> shift 1
        step(1, 60, one_lane(60, 2, 66), 4, 3, "R2");
        step(1, 60, one_lane(60, 5, 54), 4, 3, "R2");
        // R1 saturation alone, then saturation with damping floor
        step(1, 0, one_lane(0, 1, 200), 15, 9, "R1");
        step(1, 0, flat(255), 8, 0, "R1");
        step(1, 255, flat(0), 8, 1, "R2");
        // R5 extremes of the pixel range
        step(1, 0, flat(255), 15, 15, "R5");
        step(1, 255, flat(0), 15, 15, "R5");
        // R6 zero strength
        step(1, 77, rnd_bus(77, 1), 0, 5, "R6");
        step(1, 3, flat(250), 0, 0, "R6");
        // R7 bubble in the stream
        step(0, 10, flat(20), 5, 5, "R7");
        step(1, 10, flat(20), 5, 5, "R7");

        // R8 random stream, back-to-back and with gaps
        for (int k = 0; k < 600; k++) begin
            int x;
            logic v;
            x = int'($urandom % 256);
            v = (k < 300) ? 1'b1 : (($urandom % 4) != 0);
            step(v, x, rnd_bus(x, ($urandom % 3) == 0),
                 int'($urandom % 16), int'($urandom % 16), "R8");
        end
        for (int k = 0; k < 4; k++) step(0, 0, flat(0), 0, 0, "R7");

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule